// File: doc/BRIEF.md
# Synchronous Transfer Strobe Timing Generator

This block times one byte of a synchronous parallel bus transfer. A one-cycle start request latches a data byte, two mode bits taken from a configuration byte, and a period value. The block then places the byte on its data output, holds it for a setup interval, drives an active-low strobe for an assert interval, and keeps the byte stable for a hold interval after the strobe returns high. It then clears the data output and raises a one-cycle done pulse.

Every interval is at least a minimum that depends on the bus-speed profile. A clock-period parameter converts that minimum from nanoseconds to clock counts, rounding up. When fast-clock operation is selected, counts are kept in half clock cycles. A falling-edge register then lets a strobe edge fall in the middle of a cycle. The data output itself only changes on rising edges. The period input can stretch the assert and hold intervals, but it can never shorten them.

Top module: `sxfer_strobe_gen`

## Requirements
- R1: Only two bits of `cfg` are decoded. Bit 4 high selects the fast bus profile and bit 3 high selects fast-clock operation. All other bits of `cfg` have no effect on any output.
- R2: Slow profile (bit 4 low): setup is at least 55 ns, strobe low time at least 90 ns, hold after strobe negation at least 100 ns, and high time after negation at least 90 ns. With a 10 ns clock and whole-cycle counting, these are 6, 9 and 10 cycles (12, 18 and 20 half cycles).
- R3: Fast profile (bit 4 high): setup is at least 25 ns, strobe low time at least 30 ns, and hold at least 35 ns. With a 10 ns clock and whole cycles, these are 3, 3 and 4 cycles.
- R4: With bit 3 high, interval lengths are rounded up to half cycles, so a strobe edge can occur at a falling clock edge. With a 10 ns clock and the fast profile, these are 5, 6 and 7 half cycles. With bit 3 low, every strobe edge is at a rising clock edge.
- R5: The strobe low time is the larger of its minimum and `prd` clock cycles. The hold interval is the largest of the hold minimum, the low-time minimum and `prd` cycles. A small `prd` leaves the minimums unchanged.
- R6: `dat_o` takes the latched byte at the rising edge that accepts start. It stays there until the rising edge at the end of the hold interval (total half cycles rounded up to even), and it is zero at all other times.
- R7: `done` is high for exactly one cycle, starting at the rising edge where `dat_o` returns to zero. The strobe is high in that cycle.
- R8: A start request while a transfer is in progress is ignored. `cfg`, `prd` and `dat_in` are sampled only at the accepting edge.
- R9: An active-low reset acts at once, without waiting for a clock edge. It forces the strobe high, `dat_o` to zero and `done` low.
- R10: The strobe is high whenever no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used in fast-clock mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer request, sampled on rising edges while idle |
| dat_in | input | DW (8) | Byte to transfer |
| cfg | input | 8 | Configuration byte; bit 4 selects fast bus, bit 3 selects fast clock |
| prd | input | PRD_W (5) | Requested strobe phase length in clock cycles |
| strb_n | output | 1 | Active-low transfer strobe |
| dat_o | output | DW (8) | Bus data; the byte during the transfer window, zero otherwise |
| done | output | 1 | One-cycle pulse at the end of the hold interval |

## Verification
The hardest situation to reach is a strobe edge in the middle of a cycle. The falling-edge register only drives the output while the clock is low. A check at rising edges alone would never see it. For that reason the bench samples the strobe at every quarter-cycle point between edges and compares each half cycle against the expected low window. The second hard case is a repeated start during a transfer combined with new configuration values. To reach it, the bench pulses start partway through a fast-profile transfer while changing `cfg`, `prd` and `dat_in`. It then confirms that the whole strobe and data profile of the original request is unchanged.

// File: rtl/sxs_pkg.sv
package sxs_pkg;

  // Integer ceiling division for positive operands.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Minimum duration in half-clock units: exact half cycles when fine,
  // otherwise whole cycles expressed as twice their count.
  function automatic int ns_to_half(input int ns, input int clk_ps, input bit fine);
    if (fine)
      return ceil_div(ns * 2000, clk_ps);
    return 2 * ceil_div(ns * 1000, clk_ps);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int round_even(input int v);
    return v + (v & 1);
  endfunction

  // True when half slot k lies inside the strobe-low window.
  function automatic bit in_low(input int k, input int s, input int a);
    return (k >= s) && (k < s + a);
  endfunction

  typedef enum logic [1:0] {
    PRF_SLOW_WHOLE = 2'b00,
    PRF_SLOW_HALF  = 2'b01,
    PRF_FAST_WHOLE = 2'b10,
    PRF_FAST_HALF  = 2'b11
  } prf_e;

endpackage

// File: rtl/sxs_timing.sv
module sxs_timing
  import sxs_pkg::*;
#(
  parameter int CLK_PS      = 10000,
  parameter int PRD_W       = 5,
  parameter int CW          = 10,
  parameter int SET_SLOW_NS = 55,
  parameter int WID_SLOW_NS = 90,
  parameter int HLD_SLOW_NS = 100,
  parameter int SET_FAST_NS = 25,
  parameter int WID_FAST_NS = 30,
  parameter int HLD_FAST_NS = 35
) (
  input  logic             fast_bus,
  input  logic             fast_clk,
  input  logic [PRD_W-1:0] prd,
  output logic [CW-1:0]    set_h,
  output logic [CW-1:0]    low_h,
  output logic [CW-1:0]    end_h
);

  localparam int S_SW = ns_to_half(SET_SLOW_NS, CLK_PS, 1'b0);
  localparam int S_SH = ns_to_half(SET_SLOW_NS, CLK_PS, 1'b1);
  localparam int S_FW = ns_to_half(SET_FAST_NS, CLK_PS, 1'b0);
  localparam int S_FH = ns_to_half(SET_FAST_NS, CLK_PS, 1'b1);
  localparam int W_SW = ns_to_half(WID_SLOW_NS, CLK_PS, 1'b0);
  localparam int W_SH = ns_to_half(WID_SLOW_NS, CLK_PS, 1'b1);
  localparam int W_FW = ns_to_half(WID_FAST_NS, CLK_PS, 1'b0);
  localparam int W_FH = ns_to_half(WID_FAST_NS, CLK_PS, 1'b1);
  localparam int H_SW = ns_to_half(HLD_SLOW_NS, CLK_PS, 1'b0);
  localparam int H_SH = ns_to_half(HLD_SLOW_NS, CLK_PS, 1'b1);
  localparam int H_FW = ns_to_half(HLD_FAST_NS, CLK_PS, 1'b0);
  localparam int H_FH = ns_to_half(HLD_FAST_NS, CLK_PS, 1'b1);

  prf_e prf;
  int   s_min, w_min, h_min, p_half, a_len, h_len;

  assign prf = prf_e'({fast_bus, fast_clk});

  always_comb begin
    unique case (prf)
      PRF_SLOW_WHOLE: begin s_min = S_SW; w_min = W_SW; h_min = H_SW; end
      PRF_SLOW_HALF:  begin s_min = S_SH; w_min = W_SH; h_min = H_SH; end
      PRF_FAST_WHOLE: begin s_min = S_FW; w_min = W_FW; h_min = H_FW; end
      default:        begin s_min = S_FH; w_min = W_FH; h_min = H_FH; end
    endcase
    p_half = 2 * int'(prd);
    a_len  = max2(w_min, p_half);
    h_len  = max2(max2(h_min, w_min), p_half);
    set_h  = CW'(s_min);
    low_h  = CW'(a_len);
    end_h  = CW'(round_even(s_min + a_len + h_len));
  end

endmodule

// File: rtl/sxs_seq.sv
module sxs_seq
  import sxs_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dat_in,
  input  logic          fast_clk,
  input  logic [CW-1:0] set_h,
  input  logic [CW-1:0] low_h,
  input  logic [CW-1:0] end_h,
  output logic [DW-1:0] dat_o,
  output logic          done,
  output logic          busy,
  output logic          hi_q,
  output logic          lo_q,
  output logic          fc_q,
  output logic          end_now
);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic [CW-1:0] set_q, low_q, end_q;

  assign cnt_nx  = cnt_q + CW'(2);
  assign end_now = busy && (cnt_nx >= end_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      dat_o <= '0;
      cnt_q <= '0;
      set_q <= '0;
      low_q <= '0;
      end_q <= '0;
      fc_q  <= 1'b0;
      hi_q  <= 1'b1;
      lo_q  <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          cnt_q <= '0;
          set_q <= set_h;
          low_q <= low_h;
          end_q <= end_h;
          fc_q  <= fast_clk;
          dat_o <= dat_in;
          hi_q  <= !in_low(0, int'(set_h), int'(low_h));
          lo_q  <= !in_low(1, int'(set_h), int'(low_h));
        end
      end else if (end_now) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        dat_o <= '0;
        hi_q  <= 1'b1;
        lo_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_nx;
        hi_q  <= !in_low(int'(cnt_nx), int'(set_q), int'(low_q));
        lo_q  <= !in_low(int'(cnt_nx) + 1, int'(set_q), int'(low_q));
      end
    end
  end

endmodule

// File: rtl/sxs_edge.sv
module sxs_edge #(
  parameter bit HALF_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_q,
  input  logic lo_q,
  input  logic fc_q,
  output logic strb_n
);

  generate
    if (HALF_EN) begin : g_half
      logic neg_q;
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_q <= 1'b1;
        else        neg_q <= lo_q;
      end
      // First half of a cycle follows the rising-edge level, second half the falling-edge level.
      assign strb_n = fc_q ? (clk ? hi_q : neg_q) : hi_q;
    end else begin : g_whole
      logic unused_ok;
      assign unused_ok = lo_q ^ fc_q ^ rst_n ^ clk;
      assign strb_n = hi_q;
    end
  endgenerate

endmodule

// File: rtl/sxfer_strobe_gen.sv
module sxfer_strobe_gen #(
  parameter int CLK_PS  = 10000,
  parameter int DW      = 8,
  parameter int PRD_W   = 5,
  parameter int CW      = 10,
  parameter int BUS_BIT = 4,
  parameter int CLK_BIT = 3,
  parameter bit HALF_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DW-1:0]    dat_in,
  input  logic [7:0]       cfg,
  input  logic [PRD_W-1:0] prd,
  output logic             strb_n,
  output logic [DW-1:0]    dat_o,
  output logic             done
);

  logic          fast_bus_w, fast_clk_w;
  logic [CW-1:0] set_w, low_w, end_w;
  logic          busy_w, hi_w, lo_w, fc_w, end_w_now;

  assign fast_bus_w = cfg[BUS_BIT];
  assign fast_clk_w = HALF_EN ? cfg[CLK_BIT] : 1'b0;

  sxs_timing #(.CLK_PS(CLK_PS), .PRD_W(PRD_W), .CW(CW)) tim_i (
    .fast_bus (fast_bus_w),
    .fast_clk (fast_clk_w),
    .prd      (prd),
    .set_h    (set_w),
    .low_h    (low_w),
    .end_h    (end_w)
  );

  sxs_seq #(.DW(DW), .CW(CW)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dat_in   (dat_in),
    .fast_clk (fast_clk_w),
    .set_h    (set_w),
    .low_h    (low_w),
    .end_h    (end_w),
    .dat_o    (dat_o),
    .done     (done),
    .busy     (busy_w),
    .hi_q     (hi_w),
    .lo_q     (lo_w),
    .fc_q     (fc_w),
    .end_now  (end_w_now)
  );

  sxs_edge #(.HALF_EN(HALF_EN)) edge_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .hi_q   (hi_w),
    .lo_q   (lo_w),
    .fc_q   (fc_w),
    .strb_n (strb_n)
  );

endmodule

// File: rtl/sxfer_strobe_gen_chk.sv
module sxfer_strobe_gen_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic [DW-1:0] dat_o,
  input logic          busy,
  input logic          hi_q,
  input logic          lo_q
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dat_o == '0)); // R6

  AST_IDLE_NEGATED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (hi_q && lo_q)); // R10

  AST_LOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_q || !lo_q) |-> busy); // R10

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (done || $stable(dat_o))); // R8

endmodule

bind sxfer_strobe_gen sxfer_strobe_gen_chk #(.DW(DW)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .done  (done),
  .dat_o (dat_o),
  .busy  (busy_w),
  .hi_q  (hi_w),
  .lo_q  (lo_w)
);

// File: tb/sxfer_strobe_gen_tb_top.sv
`timescale 1ps/1ps
module sxfer_strobe_gen_tb_top;

  localparam int TB_CLK_PS = 10000;
  localparam int HALF_PS   = TB_CLK_PS / 2;
  localparam int QTR_PS    = TB_CLK_PS / 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] dat_in = '0;
  logic [7:0] cfg = '0;
  logic [4:0] prd = '0;
  logic       strb_n;
  logic [7:0] dat_o;
  logic       done;

  int n_chk = 0;
  int n_bad = 0;

  always #(HALF_PS) clk = ~clk;

  sxfer_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dat_in(dat_in),
    .cfg(cfg), .prd(prd), .strb_n(strb_n), .dat_o(dat_o), .done(done)
  );

  // Vector: cfg, prd, byte, setup/low/end in half cycles, requirement number.
  typedef struct packed {
    logic [7:0] c;
    logic [4:0] p;
    logic [7:0] b;
    logic [7:0] s;
    logic [7:0] a;
    logic [7:0] e;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 5'd0,  8'hA5, 8'd12, 8'd18, 8'd50, 4'd2},  // R2 slow, whole cycles
    '{8'h10, 5'd0,  8'h3C, 8'd6,  8'd6,  8'd20, 4'd3},  // R3 fast, whole cycles
    '{8'h18, 5'd0,  8'h5A, 8'd5,  8'd6,  8'd18, 4'd4},  // R4 fast, half cycles
    '{8'h18, 5'd4,  8'hC3, 8'd5,  8'd8,  8'd22, 4'd5},  // R5 period stretches, odd end rounds up
    '{8'h08, 5'd0,  8'h81, 8'd11, 8'd18, 8'd50, 4'd4},  // R4 slow, half cycles
    '{8'h10, 5'd10, 8'h7E, 8'd6,  8'd20, 8'd46, 4'd5},  // R5 long period
    '{8'h00, 5'd5,  8'h11, 8'd12, 8'd18, 8'd50, 4'd5},  // R5 short period leaves minimums
    '{8'hE7, 5'd0,  8'hF0, 8'd12, 8'd18, 8'd50, 4'd1}   // R1 undecoded bits ignored
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic run_xfer(input vec_t v, input bit disturb);
    int bad_s = 0, bad_d = 0, bad_dn = 0, first_k = -1;
    check(strb_n === 1'b1, "R10 strobe idle before start", int'(strb_n), 1);
    @(negedge clk);
    cfg = v.c; prd = v.p; dat_in = v.b; start = 1'b1;
    @(posedge clk);
    #(QTR_PS);
    for (int k = 0; k < int'(v.e); k++) begin
      logic exp_s;
      exp_s = !((k >= int'(v.s)) && (k < int'(v.s) + int'(v.a)));
      if (strb_n !== exp_s) begin
        bad_s++;
        if (first_k < 0) first_k = k;
      end
      if (dat_o !== v.b) bad_d++;
      if (done !== 1'b0) bad_dn++;
      if (k == 0) start = 1'b0;
      if (disturb && k == 6) begin
        cfg = 8'h00; prd = 5'd31; dat_in = ~v.b; start = 1'b1;
      end
      if (disturb && k == 8) start = 1'b0;
      #(HALF_PS);
    end
    if (disturb)
      check(bad_s == 0 && bad_d == 0, "R8 restart ignored, profile kept", bad_s + bad_d, 0);
    else
      check(bad_s == 0, $sformatf("R%0d strobe profile (first bad half slot %0d)", v.req, first_k), bad_s, 0);
    check(bad_d == 0, "R6 data window", bad_d, 0);
    check(bad_dn == 0, "R7 done low during transfer", bad_dn, 0);
    check(done === 1'b1, "R7 done at end of hold", int'(done), 1);
    check(dat_o === 8'h00, "R6 bus cleared at end", int'(dat_o), 0);
    check(strb_n === 1'b1, "R7 strobe high with done", int'(strb_n), 1);
    #(TB_CLK_PS);
    check(done === 1'b0, "R7 done lasts one cycle", int'(done), 0);
  endtask

  initial begin
    #(TB_CLK_PS * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(TB_CLK_PS * 3 + QTR_PS);
    check(strb_n === 1'b1 && dat_o === 8'h00 && done === 1'b0,
          "R9 reset state", {strb_n, dat_o, done}, 10'h200);
    rst_n = 1'b1;
    #(TB_CLK_PS * 2);

    for (int i = 0; i < NV; i++) begin
      run_xfer(VEC[i], 1'b0);
      #(TB_CLK_PS * 2);
    end

    // R8: second start and new inputs during a fast transfer
    run_xfer(VEC[1], 1'b1);

    // R9: reset in the middle of a strobe-low window acts at once
    @(negedge clk);
    cfg = 8'h00; prd = '0; dat_in = 8'h99; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #(TB_CLK_PS * 8);
    check(strb_n === 1'b0, "R2 strobe low mid transfer", int'(strb_n), 0);
    #(QTR_PS);
    rst_n = 1'b0;
    #1;
    check(strb_n === 1'b1 && dat_o === 8'h00 && done === 1'b0,
          "R9 asynchronous reset", {strb_n, dat_o, done}, 10'h200);
    #(TB_CLK_PS * 2);
    rst_n = 1'b1;
    #(TB_CLK_PS * 2);
    check(strb_n === 1'b1 && dat_o === 8'h00, "R10 idle after reset", {strb_n, dat_o}, 9'h100);
    run_xfer(VEC[2], 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule